// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Vector Unit

This unit sits beside a small 8-bit processor core and picks which of five interrupt sources the core should service next. The sources are external line 0, timer 0 overflow, external line 1, timer 1 overflow and the serial port. Each source brings a request flag. Each source also has an enable bit and a priority bit, and one global enable gates all of them. The unit turns the winning source into a 16-bit code-memory vector. It offers that vector to the core over a valid/ready handshake.

The unit records which of its two priority levels is being serviced. It uses that record to apply the nesting rule. A low-priority request never interrupts a running handler. A high-priority request may interrupt a low-priority handler, but not another high-priority handler. The core pulses a return strobe when a handler finishes, and that strobe releases the innermost active level.

Handshake rules: once `irq_valid` is raised, it stays high until the core raises `irq_ready`. While it waits, `irq_vec` stays frozen. A transfer happens on a clock edge where both signals are high. The core may hold `irq_ready` low for as long as it likes; the offer simply waits, and newer requests do not replace it.

Top module: `intc_top`

## Requirements
- R1: A source is eligible only when its request flag, its enable bit and `glb_en` are all 1. If any of the three is 0, that source never raises `irq_valid`.
- R2: The bit position on the flag, enable and priority buses is the source index: 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial. The vector for index i is 0x0003 + 8*i, giving 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R3: A source whose `hi_prio` bit is 1 wins over every eligible low-priority source.
- R4: Among eligible sources of the same level, the lowest index wins.
- R5: `irq_valid` rises one clock after a source becomes eligible and unblocked. It stays high until a clock edge where `irq_ready` is 1, and it is low in the cycle after that transfer.
- R6: While a high-priority level is in service, no request is offered. While only the low level is in service, only high-priority requests are offered.
- R7: A `reti` pulse releases the high level if it is in service, and otherwise the low level. A `reti` pulse with no level in service changes nothing.
- R8: While `irq_valid` is high, `irq_vec` keeps the value it had when the offer started, even if the requests change.
- R9: `irq_accept` is high for exactly the one cycle after each transfer.
- R10: After reset, `irq_valid` and `irq_accept` are 0 and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_flags | input | 5 | Per-source request flags |
| src_en | input | 5 | Per-source enable bits |
| glb_en | input | 1 | Global interrupt enable |
| hi_prio | input | 5 | Per-source priority (1 = high) |
| irq_valid | output | 1 | An interrupt is offered to the core |
| irq_ready | input | 1 | The core takes the offered interrupt |
| irq_vec | output | 16 | Vector address of the offered interrupt |
| irq_accept | output | 1 | One-cycle pulse after a transfer |
| reti | input | 1 | Return-from-interrupt strobe |

## Verification
The bench builds the unit with its default parameters. These are five sources, a base vector of 0x0003, a stride of 8 and a 16-bit address. With those values every vector and every pairing of the two levels can be reached with simple flag patterns. It runs nested sequences that stack a high-priority handler on top of a low-priority one. It then unwinds them one return at a time, so each release order and each blocked request can be observed at the handshake. It also holds `irq_ready` low while a higher request arrives, which exercises the frozen-offer rule.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;
  localparam int NUM_LVL = 2;
endpackage

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int NUM_SRC = 5,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] mask,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  // lowest set index wins: scan downward so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_level_track.sv
module intc_level_track
  import intc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  lvl_e take_lvl,
  input  logic reti,
  output logic in_hi,
  output logic in_lo
);
  logic nxt_hi, nxt_lo;

  always_comb begin
    nxt_hi = in_hi;
    nxt_lo = in_lo;
    if (reti) begin
      if (in_hi) nxt_hi = 1'b0;
      else       nxt_lo = 1'b0;
    end
    if (take) begin
      if (take_lvl == LVL_HI) nxt_hi = 1'b1;
      else                    nxt_lo = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hi <= 1'b0;
      in_lo <= 1'b0;
    end else begin
      in_hi <= nxt_hi;
      in_lo <= nxt_lo;
    end
  end

  AST_RETI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && !in_hi && !in_lo) |=> (!in_hi && !in_lo)); // R7
  AST_RETI_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && in_hi) |=> (!in_hi && (in_lo == $past(in_lo)))); // R7
  AST_NO_LO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_lvl == LVL_LO) |-> (!in_hi && !in_lo)); // R6
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC    = 5,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_flags,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               glb_en,
  input  logic [NUM_SRC-1:0] hi_prio,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [ADDR_W-1:0]  irq_vec,
  output logic               irq_accept,
  input  logic               reti
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] lvl_mask [NUM_LVL];
  logic [NUM_LVL-1:0] lvl_found;
  logic [IDX_W-1:0]   lvl_idx  [NUM_LVL];
  logic               in_hi, in_lo;
  logic               pend_vld;
  logic [IDX_W-1:0]   pend_idx;
  lvl_e               pend_lvl;
  logic               take;

  assign eligible    = req_flags & src_en & {NUM_SRC{glb_en}};
  assign lvl_mask[1] = eligible & hi_prio  & {NUM_SRC{~in_hi}};
  assign lvl_mask[0] = eligible & ~hi_prio & {NUM_SRC{~in_hi & ~in_lo}};

  for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
    intc_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .mask  (lvl_mask[lv]),
      .found (lvl_found[lv]),
      .idx   (lvl_idx[lv])
    );
  end

  assign take = pend_vld & irq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld   <= 1'b0;
      pend_idx   <= '0;
      pend_lvl   <= LVL_LO;
      irq_accept <= 1'b0;
    end else begin
      irq_accept <= take;
      if (take) begin
        pend_vld <= 1'b0;
      end else if (!pend_vld && (|lvl_found)) begin
        pend_vld <= 1'b1;
        pend_idx <= lvl_found[1] ? lvl_idx[1] : lvl_idx[0];
        pend_lvl <= lvl_found[1] ? LVL_HI : LVL_LO;
      end
    end
  end

  intc_level_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .take_lvl (pend_lvl),
    .reti     (reti),
    .in_hi    (in_hi),
    .in_lo    (in_lo)
  );

  assign irq_valid = pend_vld;
  assign irq_vec   = ADDR_W'(VEC_BASE) + ADDR_W'(pend_idx) * ADDR_W'(VEC_STRIDE);

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_vec))); // R8
  AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |=> !irq_accept); // R9
  AST_DROP_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> (!irq_valid && irq_accept)); // R5
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(glb_en)); // R1
  AST_HI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> !$past(in_hi)); // R6
endmodule

// File: tb/intc_top_tb.sv
`timescale 1ns/1ps
module intc_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  req_flags = '0, src_en = '0, hi_prio = '0;
  logic        glb_en = 1'b0, irq_ready = 1'b0, reti = 1'b0;
  logic        irq_valid, irq_accept;
  logic [15:0] irq_vec;

  int n_run = 0, n_fail = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  intc_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_flags(req_flags), .src_en(src_en),
    .glb_en(glb_en), .hi_prio(hi_prio), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vec(irq_vec), .irq_accept(irq_accept),
    .reti(reti)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every transfer is compared against the scoreboard
  always @(negedge clk) begin
    if (rst_n && irq_valid && irq_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected transfer", int'(irq_vec), 0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(irq_vec == e, t, int'(irq_vec), int'(e));
      end
    end
  end

  task automatic drv(input logic [4:0] rq, input logic [4:0] en, input logic g, input logic [4:0] hp);
    @(posedge clk); #1;
    req_flags = rq; src_en = en; glb_en = g; hi_prio = hp;
  endtask

  task automatic pulse_reti();
    @(posedge clk); #1 reti = 1'b1;
    @(posedge clk); #1 reti = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(!irq_valid, tag, int'(irq_valid), 0);
    end
  endtask

  task automatic wait_valid(input string tag);
    int k;
    k = 0;
    @(negedge clk);
    while (!irq_valid && k < 50) begin
      @(negedge clk);
      k++;
    end
    chk(irq_valid, tag, int'(irq_valid), 1);
  endtask

  // driver: push the expected vector, then complete one handshake
  task automatic take_one(input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    wait_valid({tag, " R5 offer"});
    @(posedge clk); #1 irq_ready = 1'b1;
    @(negedge clk);
    @(posedge clk); #1 irq_ready = 1'b0;
    @(negedge clk);
    chk(irq_accept, "R9 accept high", int'(irq_accept), 1);
    chk(!irq_valid, "R5 valid drops", int'(irq_valid), 0);
    @(negedge clk);
    chk(!irq_accept, "R9 accept one cycle", int'(irq_accept), 0);
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!irq_valid, "R10 valid", int'(irq_valid), 0);
    chk(!irq_accept, "R10 accept", int'(irq_accept), 0);
    // R10: nothing in service, so a low request is offered at once
    drv(5'b00001, 5'h1f, 1'b1, 5'h00);
    take_one(16'h0003, "R10 idle levels");
    drv(0, 5'h1f, 1'b1, 0); pulse_reti();

    // R2: every source alone
    for (int i = 0; i < 5; i++) begin
      drv(5'(1 << i), 5'h1f, 1'b1, 5'h00);
      take_one(16'(3 + 8 * i), "R2 vector");
      drv(0, 5'h1f, 1'b1, 0);
      pulse_reti();
    end

    // R1: each gate closed
    drv(5'h1f, 5'h1f, 1'b0, 0); idle(6, "R1 global off");
    drv(5'h1f, 5'h00, 1'b1, 0); idle(6, "R1 enables off");
    drv(5'h00, 5'h1f, 1'b1, 0); idle(6, "R1 no flags");
    drv(5'b10100, 5'b01011, 1'b1, 0); idle(6, "R1 mismatched enable");

    // R4: same level, lowest index wins
    drv(5'h1f, 5'h1f, 1'b1, 0);
    take_one(16'h0003, "R4 all low");
    drv(0, 5'h1f, 1'b1, 0); pulse_reti();
    drv(5'b11000, 5'h1f, 1'b1, 0);
    take_one(16'h001B, "R4 pair");
    drv(0, 5'h1f, 1'b1, 0); pulse_reti();

    // R3: high level beats a lower index
    drv(5'h1f, 5'h1f, 1'b1, 5'b10000);
    take_one(16'h0023, "R3 high wins");
    idle(5, "R6 low blocked under high");
    drv(0, 5'h1f, 1'b1, 0); pulse_reti();

    // R6/R7 nesting and unwinding
    drv(5'b00011, 5'h1f, 1'b1, 0);
    take_one(16'h0003, "R6 low taken");
    drv(5'b00010, 5'h1f, 1'b1, 0);
    idle(5, "R6 low cannot nest");
    drv(5'b01010, 5'h1f, 1'b1, 5'b01000);
    take_one(16'h001B, "R6 high preempts low");
    drv(5'b11010, 5'h1f, 1'b1, 5'b11000);
    idle(5, "R6 high cannot nest on high");
    pulse_reti();
    take_one(16'h001B, "R7 high released first");
    drv(5'b00010, 5'h1f, 1'b1, 0);
    pulse_reti();
    idle(5, "R7 low still in service");
    pulse_reti();
    take_one(16'h000B, "R7 low released");
    drv(0, 5'h1f, 1'b1, 0); pulse_reti();

    // R7: return with nothing in service
    pulse_reti(); pulse_reti();
    idle(3, "R7 spurious return");
    drv(5'b00100, 5'h1f, 1'b1, 0);
    take_one(16'h0013, "R7 normal after spurious");
    drv(5'b00001, 5'h1f, 1'b1, 0);
    idle(4, "R7 low level still set");
    drv(0, 5'h1f, 1'b1, 0); pulse_reti();

    // R8: frozen offer while the core stalls
    drv(5'b00100, 5'h1f, 1'b1, 0);
    wait_valid("R8 offer");
    drv(5'b00101, 5'h1f, 1'b1, 5'b00001);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(irq_valid && irq_vec == 16'h0013, "R8 held", int'(irq_vec), 16'h0013);
    end
    take_one(16'h0013, "R8 stale offer taken");
    take_one(16'h0003, "R6 high nests after hold");
    drv(0, 5'h1f, 1'b1, 0);
    pulse_reti(); pulse_reti();
    idle(3, "R7 all released");

    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule